// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block carries out, in one clock edge, the state changes a 64-bit processor with windowed registers makes when it takes a trap. A trap request arrives with a 9-bit trap type and the live context: condition codes, address space identifier, save-window count, trap base address and the current and next program counters. The block keeps the trap level, the processor state word and the current window pointer. On a taken trap it raises the level and pushes a return record into a per-level trap stack. It switches to one of three alternate global register sets and corrects the window pointer for window-management traps. It then redirects the program counters to a vector derived from the trap base address.

Near the deepest permitted level the block enters a reduced-error mode by setting a flag in the state word. A request at or beyond the maximum level is refused and latches a sticky error indication that only reset clears. A synchronous read port returns any saved stack record one cycle after its level is presented.

Top module: `trap_entry_seq`

## Requirements
- R1: After synchronous reset the trap level, state word, window pointer, program counters, trap-taken pulse and error flag are all zero.
- R2: A request with trap level below MAXTL-1 is taken: the level rises by exactly one and state bit 5 (reduced-error flag) is not newly set.
- R3: A request at level MAXTL-1 is taken, the level becomes MAXTL, and state bit 5 is set both in the live state word and in the state field saved for that trap.
- R4: A request at level MAXTL or above is not taken and sets the error flag; while the error flag is set every request is ignored (level, state, window pointer and program counters unchanged, no pulse) until reset.
- R5: The saved state record is 64 bits: condition codes in [39:32], address space identifier in [31:24], the pre-trap state word ANDed with 0xF3F in [19:8] (including a newly set bit 5), the pre-trap window pointer in the low bits, all other bits zero.
- R6: The saved PC, next PC and trap type are stored at the stack entry indexed by the new trap level; the read port returns the entry for rd_lvl_i one cycle after it is presented.
- R7: State bits: 0 alternate globals, 2 privileged, 4 FPU enable, 10 MMU globals, 11 interrupt globals. On a taken trap exactly one of bits 0/10/11 is set, bits 2 and 4 are set: type 0x060 selects bit 11; types 0x008, 0x030 and 0x064 through 0x06F select bit 10; every other type selects bit 0.
- R8: Type 0x024 (clean window) sets the window pointer to the old pointer minus one, modulo NWIN.
- R9: Types whose bits [8:6] equal 3'b010 (spill, 0x080 to 0x0BF) set the window pointer to old pointer minus cansave_i minus 2, modulo NWIN.
- R10: Types whose bits [8:6] equal 3'b011 (fill, 0x0C0 to 0x0FF) add one to the window pointer modulo NWIN; any other type, and any cycle without a taken trap, leaves it unchanged.
- R11: On a taken trap pc_o becomes tba_i with bits [14:0] cleared, bit 14 set when the new level exceeds 1, and the trap type in bits [13:5]; npc_o becomes pc_o + 4.
- R12: trap_taken_o is high for exactly the one cycle after the edge that took a trap, and all outputs change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req_i | input | 1 | Trap request, sampled each edge |
| trap_type_i | input | 9 | Trap type code |
| ccr_i | input | 8 | Condition codes to save |
| asi_i | input | 8 | Address space identifier to save |
| cansave_i | input | $clog2(NWIN) | Count of windows free for saving |
| tba_i | input | XLEN | Trap base address |
| pc_i | input | XLEN | PC of the trapping instruction |
| npc_i | input | XLEN | Next PC of the trapping instruction |
| rd_lvl_i | input | $clog2(MAXTL+1) | Trap stack level to read |
| pc_o | output | XLEN | Program counter after entry |
| npc_o | output | XLEN | Next program counter after entry |
| pstate_o | output | 12 | Processor state word |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| tl_o | output | $clog2(MAXTL+1) | Current trap level |
| trap_taken_o | output | 1 | One-cycle pulse per taken trap |
| err_o | output | 1 | Sticky error: trap refused at maximum level |
| rd_tstate_o | output | 64 | Saved state record at rd_lvl_i |
| rd_tpc_o | output | XLEN | Saved PC at rd_lvl_i |
| rd_tnpc_o | output | XLEN | Saved next PC at rd_lvl_i |
| rd_tt_o | output | 9 | Saved trap type at rd_lvl_i |

## Verification
A wrong trap level shows at once on tl_o and, one edge later, in bit 14 of pc_o and in which stack entry holds the record, so a read of the expected level returns stale or unwritten data. A wrong window pointer or state word is visible on the very next edge and is also carried into the saved record of the following trap. An off-by-one in the level limits appears only in the last two traps before saturation, so every run drives the level up to the error state and then past it.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int TT_W = 9;
  localparam int PS_W = 12;

  // state word bit positions
  localparam int PSB_AG   = 0;
  localparam int PSB_PRIV = 2;
  localparam int PSB_PEF  = 4;
  localparam int PSB_RED  = 5;
  localparam int PSB_MG   = 10;
  localparam int PSB_IG   = 11;

  localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

  // trap type codes the sequencer decodes
  localparam logic [TT_W-1:0] TT_FETCH_FAULT = 9'h008;
  localparam logic [TT_W-1:0] TT_WIN_CLEAN   = 9'h024;
  localparam logic [TT_W-1:0] TT_LOAD_FAULT  = 9'h030;
  localparam logic [TT_W-1:0] TT_VEC_INT     = 9'h060;
  localparam logic [TT_W-1:0] TT_FETCH_MISS  = 9'h064;
  localparam logic [TT_W-1:0] TT_LOAD_MISS   = 9'h068;
  localparam logic [TT_W-1:0] TT_STORE_PROT  = 9'h06C;
  localparam logic [TT_W-1:0] TT_CLASS_MASK  = 9'h1C0;
  localparam logic [TT_W-1:0] TT_SPILL_CLASS = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL_CLASS  = 9'h0C0;

  typedef enum logic [1:0] {GSET_ALT, GSET_MMU, GSET_INT} gset_e;
  typedef enum logic [1:0] {WIN_KEEP, WIN_CLEAN, WIN_SPILL, WIN_FILL} win_op_e;
endpackage

// File: rtl/trap_class_dec.sv
module trap_class_dec
  import trap_seq_pkg::*;
(
  input  logic [TT_W-1:0] tt_i,
  output gset_e           gset_o,
  output win_op_e         win_op_o
);
  logic in_mmu_range;

  always_comb begin
    in_mmu_range = (tt_i[TT_W-1:2] == TT_FETCH_MISS[TT_W-1:2]) ||
                   (tt_i[TT_W-1:2] == TT_LOAD_MISS[TT_W-1:2])  ||
                   (tt_i[TT_W-1:2] == TT_STORE_PROT[TT_W-1:2]);

    if (tt_i == TT_VEC_INT)
      gset_o = GSET_INT;
    else if ((tt_i == TT_FETCH_FAULT) || (tt_i == TT_LOAD_FAULT) || in_mmu_range)
      gset_o = GSET_MMU;
    else
      gset_o = GSET_ALT;

    if (tt_i == TT_WIN_CLEAN)
      win_op_o = WIN_CLEAN;
    else if ((tt_i & TT_CLASS_MASK) == TT_SPILL_CLASS)
      win_op_o = WIN_SPILL;
    else if ((tt_i & TT_CLASS_MASK) == TT_FILL_CLASS)
      win_op_o = WIN_FILL;
    else
      win_op_o = WIN_KEEP;
  end
endmodule

// File: rtl/trap_cwp_adj.sv
module trap_cwp_adj
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN)
) (
  input  logic [CWPW-1:0] cwp_i,
  input  logic [CWPW-1:0] cansave_i,
  input  win_op_e         op_i,
  output logic [CWPW-1:0] cwp_o
);
  localparam int AW = CWPW + 2;

  logic [AW-1:0] raw;

  // offsets kept non-negative by adding whole multiples of NWIN
  always_comb begin
    case (op_i)
      WIN_CLEAN: raw = {2'b00, cwp_i} + AW'(NWIN - 1);
      WIN_SPILL: raw = {2'b00, cwp_i} + AW'(2 * NWIN - 2) - {2'b00, cansave_i};
      WIN_FILL:  raw = {2'b00, cwp_i} + AW'(1);
      default:   raw = {2'b00, cwp_i};
    endcase
  end

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      assign cwp_o = CWPW'(raw & AW'(NWIN - 1));
    end else begin : g_mod
      assign cwp_o = CWPW'(raw % AW'(NWIN));
    end
  endgenerate
endmodule

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl #(
  parameter int MAXTL = 5,
  parameter int TLW   = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_i,
  output logic           take_o,
  output logic           red_o,
  output logic [TLW-1:0] tl_o,
  output logic [TLW-1:0] tl_next_o,
  output logic           err_o
);
  localparam logic [TLW-1:0] TL_TOP  = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_EDGE = TLW'(MAXTL - 1);

  logic [TLW-1:0] tl_q;
  logic           err_q;
  logic           refuse;

  assign take_o    = req_i && !err_q && (tl_q < TL_TOP);
  assign refuse    = req_i && !err_q && (tl_q >= TL_TOP);
  assign red_o     = (tl_q >= TL_EDGE);
  assign tl_next_o = tl_q + TLW'(1);
  assign tl_o      = tl_q;
  assign err_o     = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (take_o) tl_q  <= tl_next_o;
      if (refuse) err_q <= 1'b1;
    end
  end

  // R3
  tl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tl_q <= TL_TOP);

  // R2
  tl_step_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (tl_q == $past(tl_q) + TLW'(1)));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 201
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MAXTL = 5,
  parameter int NWIN  = 8,
  localparam int TLW  = $clog2(MAXTL + 1),
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_req_i,
  input  logic [8:0]      trap_type_i,
  input  logic [7:0]      ccr_i,
  input  logic [7:0]      asi_i,
  input  logic [CWPW-1:0] cansave_i,
  input  logic [XLEN-1:0] tba_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [TLW-1:0]  rd_lvl_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [11:0]     pstate_o,
  output logic [CWPW-1:0] cwp_o,
  output logic [TLW-1:0]  tl_o,
  output logic            trap_taken_o,
  output logic            err_o,
  output logic [63:0]     rd_tstate_o,
  output logic [XLEN-1:0] rd_tpc_o,
  output logic [XLEN-1:0] rd_tnpc_o,
  output logic [8:0]      rd_tt_o
);
  localparam int SDEPTH = 1 << TLW;
  localparam int TS_W   = 64;
  localparam int ENT_W  = TS_W + 2 * XLEN + TT_W;

  localparam logic [PS_W-1:0] PS_RED_BIT  = PS_W'(1) << PSB_RED;
  localparam logic [PS_W-1:0] PS_ENTRY    = (PS_W'(1) << PSB_PRIV) | (PS_W'(1) << PSB_PEF);
  localparam logic [PS_W-1:0] PS_GSET_ALL = (PS_W'(1) << PSB_AG) | (PS_W'(1) << PSB_MG) |
                                            (PS_W'(1) << PSB_IG);

  logic [PS_W-1:0] pstate_q;
  logic [CWPW-1:0] cwp_q;
  logic [XLEN-1:0] pc_q, npc_q;
  logic            taken_q;

  logic            take, red;
  logic [TLW-1:0]  tl_cur, tl_next;
  gset_e           gset;
  win_op_e         win_op;
  logic [CWPW-1:0] cwp_new;
  logic [PS_W-1:0] pst_base, pst_gbit, pst_new;
  logic [TS_W-1:0] ts_word;
  logic [XLEN-1:0] vec;
  logic [ENT_W-1:0] ent_wr, ent_rd;

  trap_level_ctrl #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
    .clk       (clk),
    .rst       (rst),
    .req_i     (trap_req_i),
    .take_o    (take),
    .red_o     (red),
    .tl_o      (tl_cur),
    .tl_next_o (tl_next),
    .err_o     (err_o)
  );

  trap_class_dec u_class (
    .tt_i     (trap_type_i),
    .gset_o   (gset),
    .win_op_o (win_op)
  );

  trap_cwp_adj #(.NWIN(NWIN), .CWPW(CWPW)) u_cwp (
    .cwp_i     (cwp_q),
    .cansave_i (cansave_i),
    .op_i      (win_op),
    .cwp_o     (cwp_new)
  );

  always_comb begin
    pst_base = pstate_q | (red ? PS_RED_BIT : '0);
    case (gset)
      GSET_INT: pst_gbit = PS_W'(1) << PSB_IG;
      GSET_MMU: pst_gbit = PS_W'(1) << PSB_MG;
      default:  pst_gbit = PS_W'(1) << PSB_AG;
    endcase
    pst_new = (pst_base & ~PS_GSET_ALL) | PS_ENTRY | pst_gbit;
    ts_word = {24'b0, ccr_i, asi_i, 4'b0, pst_base & PS_SAVE_MASK, 8'(cwp_q)};
    vec = (tba_i & ~XLEN'(32'h7FFF)) |
          ((tl_next >= TLW'(2)) ? XLEN'(32'h4000) : '0) |
          (XLEN'(trap_type_i) << 5);
    ent_wr = {ts_word, pc_i, npc_i, trap_type_i};
  end

  trap_state_stack #(.DEPTH(SDEPTH), .AW(TLW), .DW(ENT_W)) u_stack (
    .clk     (clk),
    .we_i    (take),
    .waddr_i (tl_next),
    .wdata_i (ent_wr),
    .raddr_i (rd_lvl_i),
    .rdata_o (ent_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate_q <= '0;
      cwp_q    <= '0;
      pc_q     <= '0;
      npc_q    <= '0;
      taken_q  <= 1'b0;
    end else begin
      taken_q <= take;
      if (take) begin
        pstate_q <= pst_new;
        cwp_q    <= cwp_new;
        pc_q     <= vec;
        npc_q    <= vec + XLEN'(4);
      end
    end
  end

  assign pc_o         = pc_q;
  assign npc_o        = npc_q;
  assign pstate_o     = pstate_q;
  assign cwp_o        = cwp_q;
  assign tl_o         = tl_cur;
  assign trap_taken_o = taken_q;
  assign {rd_tstate_o, rd_tpc_o, rd_tnpc_o, rd_tt_o} = ent_rd;

  // R7
  gset_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> ($countones({pstate_o[PSB_IG], pstate_o[PSB_MG], pstate_o[PSB_AG]}) == 1));

  // R7
  entry_priv_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> (pstate_o[PSB_PRIV] && pstate_o[PSB_PEF]));

  // R11
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> (pc_o[4:0] == 5'd0));

  // R12
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_req_i |=> (!trap_taken_o && $stable(pc_o) && $stable(cwp_o) && $stable(tl_o)));

  // R4
  err_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !trap_taken_o);
endmodule

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam int XLEN  = 64;
  localparam int MAXTL = 5;
  localparam int NWIN  = 8;
  localparam int TLW   = $clog2(MAXTL + 1);
  localparam int CWPW  = $clog2(NWIN);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trap_req_i = 1'b0;
  logic [8:0]      trap_type_i = '0;
  logic [7:0]      ccr_i = '0;
  logic [7:0]      asi_i = '0;
  logic [CWPW-1:0] cansave_i = '0;
  logic [XLEN-1:0] tba_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic [XLEN-1:0] npc_i = '0;
  logic [TLW-1:0]  rd_lvl_i = '0;
  logic [XLEN-1:0] pc_o, npc_o;
  logic [11:0]     pstate_o;
  logic [CWPW-1:0] cwp_o;
  logic [TLW-1:0]  tl_o;
  logic            trap_taken_o, err_o;
  logic [63:0]     rd_tstate_o;
  logic [XLEN-1:0] rd_tpc_o, rd_tnpc_o;
  logic [8:0]      rd_tt_o;

  trap_entry_seq #(.XLEN(XLEN), .MAXTL(MAXTL), .NWIN(NWIN)) u_trap_entry_seq (
    .clk(clk), .rst(rst), .trap_req_i(trap_req_i), .trap_type_i(trap_type_i),
    .ccr_i(ccr_i), .asi_i(asi_i), .cansave_i(cansave_i), .tba_i(tba_i),
    .pc_i(pc_i), .npc_i(npc_i), .rd_lvl_i(rd_lvl_i), .pc_o(pc_o), .npc_o(npc_o),
    .pstate_o(pstate_o), .cwp_o(cwp_o), .tl_o(tl_o), .trap_taken_o(trap_taken_o),
    .err_o(err_o), .rd_tstate_o(rd_tstate_o), .rd_tpc_o(rd_tpc_o),
    .rd_tnpc_o(rd_tnpc_o), .rd_tt_o(rd_tt_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int          m_tl;
  logic [11:0] m_pst;
  int          m_cwp;
  bit          m_err;
  logic [63:0] m_pc, m_npc;
  logic [63:0] e_ts [8];
  logic [63:0] e_pc [8];
  logic [63:0] e_npc [8];
  logic [8:0]  e_tt [8];

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] gset_bit(logic [8:0] t);
    if (t == 9'h060) return 12'h800;
    if (t == 9'h008 || t == 9'h030 || (t >= 9'h064 && t <= 9'h06F)) return 12'h400;
    return 12'h001;
  endfunction

  function automatic int next_cwp(logic [8:0] t, int c, int cs);
    if (t == 9'h024) return (c + NWIN - 1) % NWIN;
    if (t[8:6] == 3'b010) return (((c - cs - 2) % NWIN) + NWIN) % NWIN;
    if (t[8:6] == 3'b011) return (c + 1) % NWIN;
    return c;
  endfunction

  function automatic string cwp_tag(logic [8:0] t);
    if (t == 9'h024) return "R8";
    if (t[8:6] == 3'b010) return "R9";
    return "R10";
  endfunction

  function automatic logic [63:0] vector_of(logic [63:0] tba, int ntl, logic [8:0] t);
    logic [63:0] v;
    v = {tba[63:15], 15'd0};
    if (ntl > 1) v[14] = 1'b1;
    v[13:5] = t;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trap_req_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_tl = 0; m_pst = '0; m_cwp = 0; m_err = 1'b0; m_pc = '0; m_npc = '0;
  endtask

  task automatic check_reset_state();
    check("R1", "tl", 64'(tl_o), 64'd0);
    check("R1", "pstate", 64'(pstate_o), 64'd0);
    check("R1", "cwp", 64'(cwp_o), 64'd0);
    check("R1", "pc", pc_o, 64'd0);
    check("R1", "npc", npc_o, 64'd0);
    check("R1", "taken", 64'(trap_taken_o), 64'd0);
    check("R1", "err", 64'(err_o), 64'd0);
  endtask

  task automatic trap(logic [8:0] t, logic [7:0] cc, logic [7:0] as, int cs,
                      logic [63:0] tba, logic [63:0] pc, logic [63:0] npc);
    bit          exp_take;
    bit          red;
    logic [11:0] pst_b;
    @(negedge clk);
    trap_type_i = t; ccr_i = cc; asi_i = as; cansave_i = CWPW'(cs);
    tba_i = tba; pc_i = pc; npc_i = npc; trap_req_i = 1'b1;
    exp_take = 1'b0;
    red = 1'b0;
    if (!m_err) begin
      if (m_tl >= MAXTL) begin
        m_err = 1'b1;
      end else begin
        exp_take = 1'b1;
        red = (m_tl >= MAXTL - 1);
        pst_b = m_pst | (red ? 12'h020 : 12'h000);
        e_ts[m_tl + 1]  = (64'(cc) << 32) | (64'(as) << 24) |
                          (64'(pst_b & 12'hF3F) << 8) | 64'(m_cwp);
        e_pc[m_tl + 1]  = pc;
        e_npc[m_tl + 1] = npc;
        e_tt[m_tl + 1]  = t;
        m_tl  = m_tl + 1;
        m_pst = (pst_b & ~12'hC01) | 12'h014 | gset_bit(t);
        m_cwp = next_cwp(t, m_cwp, cs);
        m_pc  = vector_of(tba, m_tl, t);
        m_npc = m_pc + 64'd4;
      end
    end
    @(negedge clk);
    trap_req_i = 1'b0;
    check("R12", "taken", 64'(trap_taken_o), 64'(exp_take));
    check("R4", "err", 64'(err_o), 64'(m_err));
    check(exp_take ? (red ? "R3" : "R2") : "R4", "level", 64'(tl_o), 64'(m_tl));
    check(exp_take ? "R7" : "R4", "pstate", 64'(pstate_o), 64'(m_pst));
    check(exp_take ? cwp_tag(t) : "R4", "cwp", 64'(cwp_o), 64'(m_cwp));
    check(exp_take ? "R11" : "R4", "pc", pc_o, m_pc);
    check(exp_take ? "R11" : "R4", "npc", npc_o, m_npc);
    if (exp_take) begin
      check(red ? "R3" : "R2", "red bit", 64'(pstate_o[5]), 64'(red));
      rd_lvl_i = TLW'(m_tl);
      @(negedge clk);
      check("R5", "saved state", rd_tstate_o, e_ts[m_tl]);
      check("R6", "saved pc", rd_tpc_o, e_pc[m_tl]);
      check("R6", "saved npc", rd_tnpc_o, e_npc[m_tl]);
      check("R6", "saved type", 64'(rd_tt_o), 64'(e_tt[m_tl]));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    trap_req_i = 1'b0;
    trap_type_i = 9'($urandom);
    @(negedge clk);
    check("R12", "idle taken", 64'(trap_taken_o), 64'd0);
    check("R12", "idle pc", pc_o, m_pc);
    check("R10", "idle cwp", 64'(cwp_o), 64'(m_cwp));
  endtask

  function automatic logic [8:0] pick_type();
    case ($urandom % 9)
      0: return 9'h024;
      1: return 9'h080 + 9'($urandom % 64);
      2: return 9'h0C0 + 9'($urandom % 64);
      3: return 9'h060;
      4: return 9'h064 + 9'($urandom % 12);
      5: return ($urandom % 2) ? 9'h008 : 9'h030;
      default: return 9'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    check_reset_state();

    // directed walk to the top level and beyond
    trap(9'h024, 8'hA5, 8'h80, 0, 64'h0000_0000_0040_0000, 64'h1000, 64'h1004); // R8 0 -> 7
    trap(9'h085, 8'h3C, 8'h14, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2000, 64'h2008); // R9 7-3-2=2, bit14 set
    trap(9'h0C3, 8'h01, 8'hFF, 5, 64'h1234_5678_9ABC_DEF0, 64'h3000, 64'h3004); // R10 2 -> 3
    trap(9'h060, 8'h77, 8'h0A, 1, 64'h0000_0000_0000_8000, 64'h4000, 64'h4004); // R7 interrupt set
    trap(9'h06A, 8'h5A, 8'h22, 2, 64'h8000_0000_0000_0000, 64'h5000, 64'h5004); // R3 red entry, MMU set
    trap(9'h010, 8'h11, 8'h33, 0, 64'h0, 64'h6000, 64'h6004);                   // R4 refused
    trap(9'h024, 8'h11, 8'h33, 0, 64'h0, 64'h7000, 64'h7004);                   // R4 ignored
    idle();
    do_reset();
    @(negedge clk);
    check_reset_state();
    trap(9'h0BF, 8'h00, 8'h00, 7, 64'hDEAD_0000_BEEF_7FFF, 64'h8000, 64'h8004); // R9 wrap 0-7-2
    trap(9'h0FF, 8'h00, 8'h00, 0, 64'h0, 64'h9000, 64'h9004);                  // R10 fill wrap
    trap(9'h06F, 8'h00, 8'h00, 0, 64'h0, 64'hA000, 64'hA004);                  // R7 last MMU code
    trap(9'h070, 8'h00, 8'h00, 0, 64'h0, 64'hB000, 64'hB004);                  // R7 just outside

    for (int i = 0; i < 600; i++) begin
      if ((m_err || m_tl == MAXTL) && ($urandom % 3 == 0)) begin
        do_reset();
      end else if ($urandom % 5 == 0) begin
        idle();
      end else begin
        trap(pick_type(), 8'($urandom), 8'($urandom), int'($urandom % NWIN),
             {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule